// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is a bus-attached SPI master. Software programs a control word that picks one of three chip-select lines, the clock polarity and phase, and the active level of each select line. It also sets an even clock divider. Software then sets the transfer-active bit and pushes bytes into a 16-entry transmit FIFO through the data port. While transfer-active is set, the engine takes bytes from the transmit FIFO one at a time and shifts each out MSB first. It captures the byte returned on the input line into a 16-entry receive FIFO, and software pops that FIFO through the same data port.

Status bits report transmit room, receive data, a receive FIFO that is three-quarters full, a full receive FIFO, and completion. Completion means the controller is active, the transmit FIFO is empty and no byte is in flight. A single interrupt line combines completion and receive-level events, each gated by its own enable. Clearing transfer-active ends any byte in progress at once and releases the chip select.

The register bus uses a 2-bit word index: 0 is control/status, 1 is the data port and 2 is the clock divider. Writes and reads take effect in the cycle the strobe is high. Read data is combinational on the index.

Top module: `spi_host_regs`

## Requirements
- R1: Control word layout: [1:0] chip-select index, [2] CPHA, [3] CPOL, [6] global active-high select, [7] transfer active, [9] done-interrupt enable, [10] receive-interrupt enable, [23:21] per-line active-high select for lines 2..0. All of these read back as written. Writing 1 to bit 4 empties the transmit FIFO and writing 1 to bit 5 empties the receive FIFO; both bits always read as 0.
- R2: Read-only status in the control word: [16] done, [17] receive FIFO not empty, [18] transmit FIFO not full, [19] receive FIFO holds at least 12 bytes, [20] receive FIFO full.
- R3: The divider register holds 16 bits. SCLK half-period is floor(D/2) core cycles, and a divider of 0 or 1 gives a half-period of 32768 cycles (period 65536).
- R4: Bytes shift MSB first in standard SPI modes. SCLK idles at CPOL. With CPHA=0 data is valid before the first edge and sampled on odd-numbered (leading) edges. With CPHA=1 data changes on leading edges and is sampled on trailing edges. Each byte uses exactly 16 SCLK edges.
- R5: Line i is active at level 1 when bit 6 or its per-line bit is set, otherwise at level 0. It is driven active only while transfer-active is set and the index equals i, and it sits at the opposite level otherwise. Index 3 selects no line.
- R6: The transmit FIFO holds 16 bytes. A data-port write to a full transmit FIFO is dropped.
- R7: A data-port read pops the oldest received byte into bits [7:0]. A read of an empty receive FIFO returns 0 and changes nothing.
- R8: No new byte starts while the receive FIFO is full. Shifting resumes once a byte is popped.
- R9: The clear controls take effect in the cycle of the write and leave the FIFO empty.
- R10: Done is 1 exactly when transfer-active is set, the transmit FIFO is empty and no byte is shifting.
- R11: The interrupt output is high when (done-enable and done) or (receive-enable and receive at least 12).
- R12: Clearing transfer-active aborts a byte in flight, returns SCLK to CPOL and releases the chip select.
- R13: After reset every control bit and the divider are 0, both FIFOs are empty, all select lines are at level 1 and SCLK, MOSI and the interrupt are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive FIFO at index 1) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs | output | 3 | Chip-select lines |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is a transmit byte held back because the receive FIFO is full. Reaching it needs sixteen bytes already received and unread, followed by one more queued byte. The bench loads seventeen bytes while inactive, so the last is dropped. It then activates with a loopback on the serial lines until the receive FIFO fills, queues one more byte and confirms that no clock edges or completion follow. After one pop, it checks that the held byte arrives last in order. The very slow default divider is reached by timing only two clock edges and then aborting mid-byte, which also checks that the abort releases the select line.

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic [2:0]  spi_cs,
  output logic        irq
);
  localparam int PW = $clog2(FIFO_DEPTH);
  localparam int CW = PW + 1;
  localparam int RX_HIGH = (FIFO_DEPTH * 3) / 4;

  logic [1:0]  csel;
  logic        cpha, cpol, pol_all, active, en_done, en_rx;
  logic [2:0]  pol_line;
  logic [15:0] div;

  logic [7:0]    tx_mem [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic [7:0]    rx_mem [FIFO_DEPTH];
  logic [PW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;

  logic        busy, sclk_r;
  logic [3:0]  edge_cnt;
  logic [15:0] hcnt;
  logic [7:0]  txsh, rxsh;

  wire ctrl_wr = bus_wr && bus_addr == 2'd0;
  wire data_wr = bus_wr && bus_addr == 2'd1;
  wire div_wr  = bus_wr && bus_addr == 2'd2;
  wire data_rd = bus_rd && bus_addr == 2'd1;
  wire clr_tx  = ctrl_wr && bus_wdata[4];
  wire clr_rx  = ctrl_wr && bus_wdata[5];

  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  wire rx_high  = rx_cnt >= CW'(RX_HIGH);

  wire [15:0] half = (div[15:1] == 15'd0) ? 16'h8000 : {1'b0, div[15:1]};
  wire tick   = busy && hcnt == 16'd0;
  wire start  = active && !busy && !tx_empty && !rx_full;
  wire finish = tick && edge_cnt == 4'd15;
  wire [7:0] rx_byte = cpha ? {rxsh[6:0], spi_miso} : rxsh;

  wire tx_push = data_wr && !tx_full;
  wire tx_pop  = start;
  wire rx_push = finish && !rx_full;
  wire rx_pop  = data_rd && !rx_empty;

  wire done = active && tx_empty && !busy;

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[20:11], bus_wdata[8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel <= '0; cpha <= 1'b0; cpol <= 1'b0; pol_all <= 1'b0;
      active <= 1'b0; en_done <= 1'b0; en_rx <= 1'b0; pol_line <= '0;
      div <= '0;
    end else begin
      if (ctrl_wr) begin
        csel     <= bus_wdata[1:0];
        cpha     <= bus_wdata[2];
        cpol     <= bus_wdata[3];
        pol_all  <= bus_wdata[6];
        active   <= bus_wdata[7];
        en_done  <= bus_wdata[9];
        en_rx    <= bus_wdata[10];
        pol_line <= bus_wdata[23:21];
      end
      if (div_wr) div <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= (tx_wp == PW'(FIFO_DEPTH - 1)) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == PW'(FIFO_DEPTH - 1)) ? '0 : tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= (rx_wp == PW'(FIFO_DEPTH - 1)) ? '0 : rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= (rx_rp == PW'(FIFO_DEPTH - 1)) ? '0 : rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; sclk_r <= 1'b0; edge_cnt <= '0; hcnt <= '0;
      txsh <= '0; rxsh <= '0;
    end else if (!active) begin
      busy <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      hcnt     <= half - 16'd1;
      edge_cnt <= '0;
      txsh     <= tx_mem[tx_rp];
      sclk_r   <= cpol;
    end else if (busy) begin
      if (hcnt == 16'd0) begin
        hcnt   <= half - 16'd1;
        sclk_r <= ~sclk_r;
        if (edge_cnt[0] == cpha) rxsh <= {rxsh[6:0], spi_miso};
        if (edge_cnt[0] != cpha && edge_cnt != 4'd0) txsh <= {txsh[6:0], 1'b0};
        if (edge_cnt == 4'd15) busy <= 1'b0;
        else edge_cnt <= edge_cnt + 4'd1;
      end else begin
        hcnt <= hcnt - 16'd1;
      end
    end
  end

  assign spi_sclk = busy ? sclk_r : cpol;
  assign spi_mosi = busy & txsh[7];

  for (genvar i = 0; i < 3; i++) begin : g_cs
    wire lvl = pol_all | pol_line[i];
    assign spi_cs[i] = (active && csel == 2'(i)) ? lvl : ~lvl;
  end

  assign irq = (en_done & done) | (en_rx & rx_high);

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = {8'd0, pol_line, rx_full, rx_high, !tx_full, !rx_empty, done,
                         5'd0, en_rx, en_done, 1'b0, active, pol_all, 2'b00,
                         cpol, cpha, csel};
      2'd1: bus_rdata = {24'd0, rx_empty ? 8'd0 : rx_mem[rx_rp]};
      2'd2: bus_rdata = {16'd0, div};
      default: bus_rdata = '0;
    endcase
  end
endmodule

module spi_host_regs_chk #(
  parameter int FIFO_DEPTH = 16,
  parameter int CW = $clog2(FIFO_DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          busy,
  input logic          cpol,
  input logic          pol_all,
  input logic [2:0]    pol_line,
  input logic          en_done,
  input logic          en_rx,
  input logic          spi_sclk,
  input logic [2:0]    spi_cs,
  input logic          irq,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  wire [2:0] idle_lvl = ~({3{pol_all}} | pol_line);

  assert_tx_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(FIFO_DEPTH));
  assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(FIFO_DEPTH));
  assert_rx_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt > $past(rx_cnt)) |-> (rx_cnt == $past(rx_cnt) + 1'b1));
  assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (spi_cs == idle_lvl));
  assert_cs_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(spi_cs ^ idle_lvl) <= 1);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_sclk == cpol));
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !busy);
  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_done || en_rx));
endmodule

bind spi_host_regs spi_host_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .busy(busy), .cpol(cpol),
  .pol_all(pol_all), .pol_line(pol_line), .en_done(en_done), .en_rx(en_rx),
  .spi_sclk(spi_sclk), .spi_cs(spi_cs), .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_spi_host_regs.sv
module test_spi_host_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sclk, spi_mosi, spi_miso;
  logic [2:0]  spi_cs;
  logic        irq;
  logic        miso_inv = 1'b0;

  int n_chk = 0, n_fail = 0;

  logic       mon_en = 1'b0, tb_cpol = 1'b0, tb_cpha = 1'b0;
  logic [7:0] mon_byte = '0;
  int         mon_cnt = 0;
  time        last_t = 0, last_gap = 0;

  always #4 clk = ~clk;
  assign spi_miso = miso_inv ? ~spi_mosi : spi_mosi;

  spi_host_regs i_spi_host_regs (.*);

  always @(spi_sclk) if (mon_en) begin
    if ((spi_sclk == 1'b1) == (tb_cpol == tb_cpha)) mon_byte = {mon_byte[6:0], spi_mosi};
    if (mon_cnt > 0) last_gap = $time - last_t;
    last_t = $time;
    mon_cnt++;
  end

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_done(input string req);
    logic [31:0] v;
    bit got = 0;
    for (int k = 0; k < 3000 && !got; k++) begin
      rd(2'd0, v);
      got = v[16];
    end
    check(got, req, {31'd0, got}, 32'd1);
  endtask

  task automatic mon_reset;
    mon_byte = '0; mon_cnt = 0; last_gap = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check(spi_cs == 3'b111 && spi_sclk == 1'b0 && spi_mosi == 1'b0 && irq == 1'b0, "R13 pins",
          {26'd0, spi_cs, spi_sclk, spi_mosi, irq}, 32'h38);
    rd(2'd0, v); check(v == 32'h0004_0000, "R13 ctrl", v, 32'h0004_0000);
    rd(2'd2, v); check(v == 32'd0, "R13 divider", v, 32'd0);
    rd(2'd1, v); check(v == 32'd0, "R7 empty read", v, 32'd0);
  endtask

  task automatic t_mode(input bit pol, input bit pha, input bit inv, input logic [7:0] b);
    logic [31:0] v;
    logic [31:0] ctrl = 32'h80 | (32'(pha) << 2) | (32'(pol) << 3);
    mon_en = 1'b0; tb_cpol = pol; tb_cpha = pha; miso_inv = inv;
    wr(2'd2, 32'd2);
    wr(2'd0, ctrl);
    rd(2'd0, v); check(v[31:0] == (ctrl | 32'h0005_0000), "R1 readback", v, ctrl | 32'h0005_0000);
    mon_reset(); mon_en = 1'b1;
    wr(2'd1, {24'd0, b});
    wait_done("R10 done after byte");
    mon_en = 1'b0;
    check(mon_byte == b, "R4 MSB-first on MOSI", {24'd0, mon_byte}, {24'd0, b});
    check(mon_cnt == 16, "R4 edge count", mon_cnt, 16);
    rd(2'd0, v); check(v[17] == 1'b1, "R2 rx data flag", {31'd0, v[17]}, 1);
    rd(2'd1, v); check(v == {24'd0, inv ? ~b : b}, "R4 captured byte", v, {24'd0, inv ? ~b : b});
    wr(2'd0, 32'h0);
  endtask

  task automatic t_cs;
    wr(2'd0, 32'h0040_0000);
    #1 check(spi_cs == 3'b101, "R5 idle per-line", spi_cs, 3'b101);
    wr(2'd0, 32'h0040_0081);
    #1 check(spi_cs == 3'b111, "R5 line1 active high", spi_cs, 3'b111);
    wr(2'd0, 32'h0040_0083);
    #1 check(spi_cs == 3'b101, "R5 index 3 none", spi_cs, 3'b101);
    wr(2'd0, 32'h0000_0040);
    #1 check(spi_cs == 3'b000, "R5 global idle", spi_cs, 3'b000);
    wr(2'd0, 32'h0000_00C2);
    #1 check(spi_cs == 3'b100, "R5 line2 active", spi_cs, 3'b100);
    wr(2'd0, 32'h0);
    #1 check(spi_cs == 3'b111, "R12 released", spi_cs, 3'b111);
  endtask

  task automatic t_period(input logic [15:0] d, input int half);
    tb_cpol = 1'b0; tb_cpha = 1'b0; miso_inv = 1'b0;
    wr(2'd2, {16'd0, d});
    wr(2'd0, 32'h80);
    mon_reset(); mon_en = 1'b1;
    wr(2'd1, 32'h5A);
    wait_done("R3 byte completes");
    mon_en = 1'b0;
    check(last_gap == time'(half * 8), "R3 half period", 32'(last_gap), 32'(half * 8));
    wr(2'd0, 32'h20);
  endtask

  task automatic t_slow_abort;
    tb_cpol = 1'b1; tb_cpha = 1'b0;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h88);
    mon_reset(); mon_en = 1'b1;
    wr(2'd1, 32'hC3);
    for (int k = 0; k < 70000 && mon_cnt < 2; k++) @(posedge clk);
    check(last_gap == time'(32768 * 8), "R3 divider zero", 32'(last_gap), 32'(32768 * 8));
    mon_en = 1'b0;
    wr(2'd0, 32'h08);
    #1 check(spi_sclk == 1'b1 && spi_cs == 3'b111, "R12 abort idle", {30'd0, spi_sclk, spi_cs[0]}, 32'h3);
    repeat (4) @(negedge clk);
    check(spi_sclk == 1'b1, "R12 stays idle", spi_sclk, 1);
    wr(2'd0, 32'h30);
  endtask

  task automatic t_full_stall;
    logic [31:0] v;
    tb_cpol = 1'b0; tb_cpha = 1'b0; miso_inv = 1'b0;
    wr(2'd2, 32'd2);
    wr(2'd0, 32'h0);
    for (int i = 0; i < 17; i++) wr(2'd1, 32'h10 + i);
    rd(2'd0, v); check(v[18] == 1'b0, "R6 tx full flag", {31'd0, v[18]}, 0);
    wr(2'd0, 32'h80);
    wait_done("R6 drain");
    rd(2'd0, v); check(v[20:19] == 2'b11, "R2 rx full and high", {30'd0, v[20:19]}, 3);
    mon_reset(); mon_en = 1'b1;
    wr(2'd1, 32'h77);
    repeat (40) @(negedge clk);
    rd(2'd0, v); check(v[16] == 1'b0 && mon_cnt == 0, "R8 stalled", {v[16], 31'(mon_cnt)}, 0);
    mon_en = 1'b0;
    rd(2'd1, v); check(v == 32'h10, "R7 order first", v, 32'h10);
    wait_done("R8 resumes");
    for (int i = 1; i < 16; i++) begin
      rd(2'd1, v); check(v == 32'h10 + i, "R7 order", v, 32'h10 + i);
    end
    rd(2'd1, v); check(v == 32'h77, "R6 R8 held byte last", v, 32'h77);
    rd(2'd0, v); check(v[17] == 1'b0, "R7 rx drained", {31'd0, v[17]}, 0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(2'd0, 32'h0);
    for (int i = 0; i < 3; i++) wr(2'd1, 32'hA0 + i);
    rd(2'd0, v); check(v[16] == 1'b0, "R10 inactive not done", {31'd0, v[16]}, 0);
    mon_reset(); mon_en = 1'b1;
    wr(2'd0, 32'h90);
    rd(2'd0, v); check(v == 32'h0005_0080, "R9 R1 clear tx", v, 32'h0005_0080);
    check(mon_cnt == 0, "R9 nothing shifted", mon_cnt, 0);
    mon_en = 1'b0;
    wr(2'd1, 32'h01); wr(2'd1, 32'h02);
    wait_done("R9 transfer");
    rd(2'd0, v); check(v[17] == 1'b1, "R2 rx holds data", {31'd0, v[17]}, 1);
    wr(2'd0, 32'hA0);
    rd(2'd0, v); check(v[17] == 1'b0 && v[5:4] == 2'b00, "R9 clear rx", v, 32'h0005_0080);
    rd(2'd1, v); check(v == 32'd0, "R9 rx empty read", v, 0);
    wr(2'd0, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(2'd2, 32'd2);
    wr(2'd0, 32'h280);
    @(negedge clk); check(irq == 1'b1, "R11 done irq", irq, 1);
    wr(2'd0, 32'h400);
    check(irq == 1'b0, "R11 rx irq low", irq, 0);
    for (int i = 0; i < 11; i++) wr(2'd1, 32'h30 + i);
    wr(2'd0, 32'h480);
    wait_done("R11 eleven bytes");
    check(irq == 1'b0, "R11 below level", irq, 0);
    wr(2'd1, 32'h3B);
    wait_done("R11 twelfth byte");
    check(irq == 1'b1, "R11 level reached", irq, 1);
    wr(2'd0, 32'h20);
    @(negedge clk); check(irq == 1'b0, "R11 cleared", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(1'b0, 1'b0, 1'b0, 8'hA5);
    t_mode(1'b0, 1'b1, 1'b1, 8'h3C);
    t_mode(1'b1, 1'b0, 1'b1, 8'h81);
    t_mode(1'b1, 1'b1, 1'b0, 8'h96);
    t_cs();
    t_period(16'd6, 3);
    t_period(16'd7, 3);
    t_full_stall();
    t_clear();
    t_irq();
    t_slow_abort();
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule